// File: doc/BRIEF.md
# Programmable Frame-Rate Line Timing Generator

This block paces the readout of an image sensor. On every cycle where the master clock enable is high it advances a clock-within-line counter and a line-within-frame counter. From those counters it decodes a line-active flag, a frame-active flag, and line-start and frame-start strobes. It also presents the longest exposure length that fits in the selected frame period.

A 3-bit rate code and an extended-line mode bit select the timing. With the mode bit clear, every line has the same length, and slower rates come from appending vertical-blank lines after a fixed set of active lines. With the mode bit set, the frame has only the active lines, and slower rates come from lengthening the horizontal blank at the end of each line.

Software may change the code and the mode at any time. The block captures them only while in reset, or on the enabled cycle that closes a frame. A running frame therefore always completes with the timing it started with.

Top module: `frame_line_timer`

## Requirements
- R1: On synchronous reset `clk_cnt` and `line_cnt` become 0 and both strobes are low while `clk_en` is low.
- R2: With the mode bit clear, each line lasts 1716 enabled cycles (`clk_cnt` 0..1715), and `line_active` is high exactly when `clk_cnt` < 1408.
- R3: With the mode bit clear, a frame has 467, 583, 700, 933, 1166, 1749, 3497 or 13987 lines for rate codes 0 through 7, and `line_cnt` returns to 0 after the last line.
- R4: `frame_active` is high exactly when `line_cnt` < 289, in both modes.
- R5: With the mode bit set, a frame has 289 lines, `line_active` is high exactly when `clk_cnt` < 2816, and a line lasts 3464, 4152, 5536, 6920, 10384, 20760 or 83048 enabled cycles for codes 1 through 7.
- R6: With the mode bit set, rate code 0 gives the same timing and exposure limit as code 1.
- R7: `line_start` is high on a cycle with `clk_en` high and `clk_cnt` = 0; `frame_start` is high when, in addition, `line_cnt` = 0.
- R8: While `clk_en` is low, both counters hold and both strobes are low.
- R9: Code and mode are captured during reset and on the enabled cycle where the last clock of the last line ends. Changes at other times have no effect on the timing or the exposure limit until then.
- R10: `max_expo` shows the exposure limit of the captured setting:
  - mode clear, codes 0..7: 99957, 124839, 149935, 199914, 249892, 374946, 749892, 2097151;
  - mode set, codes 1..7: 124704, 149472, 199296, 249120, 373824, 747360, 2097151.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Master clock enable; counters advance when high |
| rate_code | input | 3 | Requested frame-rate code |
| ext_mode | input | 1 | Requested extended-line mode |
| clk_cnt | output | 17 | Clock position within the current line |
| line_cnt | output | 14 | Line position within the current frame |
| line_active | output | 1 | Active portion of the line |
| frame_active | output | 1 | Active lines of the frame |
| line_start | output | 1 | Strobe on the first enabled clock of a line |
| frame_start | output | 1 | Strobe on the first enabled clock of a frame |
| max_expo | output | 21 | Exposure limit for the captured setting |

## Verification
The frame wrap and the capture of a new setting can fall in the same cycle. A code or mode change can arrive exactly on the enabled cycle that closes a frame, or while `clk_en` is low on that last clock. The bench provokes this by changing code and mode on every cycle under random gaps in `clk_en`, on an instance whose tables are shrunk so that frames take tens of cycles. A behavioural model captures the setting only at the wrap it computes itself, and every output is compared with it on every cycle.

// File: rtl/frt_pkg.sv
package frt_pkg;

    typedef logic [0:7][31:0] tbl_t;

    // Lines per frame in fixed-line-length mode, indexed by rate code
    localparam tbl_t NRM_LINES_DEF = '{32'd467, 32'd583, 32'd700, 32'd933,
                                       32'd1166, 32'd1749, 32'd3497, 32'd13987};
    // Line length in stretched-blank mode; entry 0 is never selected
    localparam tbl_t EXT_LEN_DEF   = '{32'd3464, 32'd3464, 32'd4152, 32'd5536,
                                       32'd6920, 32'd10384, 32'd20760, 32'd83048};
    localparam tbl_t NRM_EXPO      = '{32'd99957, 32'd124839, 32'd149935, 32'd199914,
                                       32'd249892, 32'd374946, 32'd749892, 32'd2097151};
    localparam tbl_t EXT_EXPO      = '{32'd124704, 32'd124704, 32'd149472, 32'd199296,
                                       32'd249120, 32'd373824, 32'd747360, 32'd2097151};

    typedef struct packed {
        logic [2:0] code;
        logic       ext;
    } cfg_t;

endpackage

// File: rtl/frt_cfg_latch.sv
module frt_cfg_latch (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [2:0]      code_in,
    input  logic            ext_in,
    output frt_pkg::cfg_t   cfg_q
);
    frt_pkg::cfg_t cfg_d;

    always_comb begin
        cfg_d = cfg_q;
        if (rst || load) begin
            cfg_d.code = code_in;
            cfg_d.ext  = ext_in;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    // R9: no capture away from a frame wrap
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/frt_lookup.sv
module frt_lookup #(
    parameter int CLK_W  = 17,
    parameter int LINE_W = 14,
    parameter int EXPO_W = 21,
    parameter int NRM_LEN = 1716,
    parameter int NRM_ACT = 1408,
    parameter int EXT_ACT = 2816,
    parameter int V_ACT   = 289,
    parameter frt_pkg::tbl_t NRM_LINES = frt_pkg::NRM_LINES_DEF,
    parameter frt_pkg::tbl_t EXT_LEN   = frt_pkg::EXT_LEN_DEF
) (
    input  frt_pkg::cfg_t       cfg,
    output logic [CLK_W-1:0]    line_len,
    output logic [CLK_W-1:0]    h_act,
    output logic [LINE_W-1:0]   frame_lines,
    output logic [EXPO_W-1:0]   expo
);
    logic [2:0] idx;

    always_comb begin
        // code 0 has no stretched-blank timing of its own: borrow code 1
        idx = (cfg.ext && cfg.code == 3'd0) ? 3'd1 : cfg.code;
        if (cfg.ext) begin
            line_len    = CLK_W'(EXT_LEN[idx]);
            h_act       = CLK_W'(EXT_ACT);
            frame_lines = LINE_W'(V_ACT);
            expo        = EXPO_W'(frt_pkg::EXT_EXPO[idx]);
        end else begin
            line_len    = CLK_W'(NRM_LEN);
            h_act       = CLK_W'(NRM_ACT);
            frame_lines = LINE_W'(NRM_LINES[idx]);
            expo        = EXPO_W'(frt_pkg::NRM_EXPO[idx]);
        end
    end

endmodule

// File: rtl/frt_raster.sv
module frt_raster #(
    parameter int CLK_W  = 17,
    parameter int LINE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [CLK_W-1:0]  line_len,
    input  logic [LINE_W-1:0] frame_lines,
    output logic [CLK_W-1:0]  hcnt,
    output logic [LINE_W-1:0] vcnt,
    output logic              line_start,
    output logic              frame_start,
    output logic              frame_wrap
);
    typedef struct packed {
        logic [CLK_W-1:0]  h;
        logic [LINE_W-1:0] v;
    } st_t;

    st_t  s_d, s_q;
    logic line_end, last_line;

    always_comb begin
        s_d        = s_q;
        line_end   = (s_q.h == line_len - 1'b1);
        last_line  = (s_q.v == frame_lines - 1'b1);
        frame_wrap = clk_en && line_end && last_line;
        if (rst) begin
            s_d = '0;
        end else if (clk_en) begin
            if (line_end) begin
                s_d.h = '0;
                s_d.v = last_line ? '0 : s_q.v + 1'b1;
            end else begin
                s_d.h = s_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign hcnt        = s_q.h;
    assign vcnt        = s_q.v;
    assign line_start  = clk_en && (s_q.h == '0);
    assign frame_start = line_start && (s_q.v == '0);

    p_h_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        hcnt < line_len);
    p_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(hcnt) && $stable(vcnt)));
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (hcnt == '0 && vcnt == '0));
    p_fs_in_ls_r7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

endmodule

// File: rtl/frame_line_timer.sv
module frame_line_timer #(
    parameter int CLK_W  = 17,
    parameter int LINE_W = 14,
    parameter int EXPO_W = 21,
    parameter int NRM_LEN = 1716,
    parameter int NRM_ACT = 1408,
    parameter int EXT_ACT = 2816,
    parameter int V_ACT   = 289,
    parameter frt_pkg::tbl_t NRM_LINES = frt_pkg::NRM_LINES_DEF,
    parameter frt_pkg::tbl_t EXT_LEN   = frt_pkg::EXT_LEN_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic [2:0]        rate_code,
    input  logic              ext_mode,
    output logic [CLK_W-1:0]  clk_cnt,
    output logic [LINE_W-1:0] line_cnt,
    output logic              line_active,
    output logic              frame_active,
    output logic              line_start,
    output logic              frame_start,
    output logic [EXPO_W-1:0] max_expo
);
    frt_pkg::cfg_t     cfg_q;
    logic [CLK_W-1:0]  line_len, h_act;
    logic [LINE_W-1:0] frame_lines;
    logic              frame_wrap;

    frt_cfg_latch u_cfg (
        .clk(clk), .rst(rst), .load(frame_wrap),
        .code_in(rate_code), .ext_in(ext_mode), .cfg_q(cfg_q)
    );

    frt_lookup #(
        .CLK_W(CLK_W), .LINE_W(LINE_W), .EXPO_W(EXPO_W),
        .NRM_LEN(NRM_LEN), .NRM_ACT(NRM_ACT), .EXT_ACT(EXT_ACT), .V_ACT(V_ACT),
        .NRM_LINES(NRM_LINES), .EXT_LEN(EXT_LEN)
    ) u_lut (
        .cfg(cfg_q), .line_len(line_len), .h_act(h_act),
        .frame_lines(frame_lines), .expo(max_expo)
    );

    frt_raster #(.CLK_W(CLK_W), .LINE_W(LINE_W)) u_ras (
        .clk(clk), .rst(rst), .clk_en(clk_en),
        .line_len(line_len), .frame_lines(frame_lines),
        .hcnt(clk_cnt), .vcnt(line_cnt),
        .line_start(line_start), .frame_start(frame_start),
        .frame_wrap(frame_wrap)
    );

    assign line_active  = (clk_cnt < h_act);
    assign frame_active = (line_cnt < LINE_W'(V_ACT));

    p_ext_lines_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_q.ext |-> (line_cnt < LINE_W'(V_ACT)));
    p_blank_tail_r2: assert property (@(posedge clk) disable iff (rst)
        (line_active && !$past(line_active)) |-> (clk_cnt == '0));

endmodule

// File: tb/sim_frame_line_timer.sv
module sim_frame_line_timer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk_en = 1'b0;
    logic [2:0] rate_code = 3'd0;
    logic ext_mode = 1'b0;

    always #5 clk = ~clk;

    logic [16:0] cc [2];
    logic [13:0] lc [2];
    logic la [2], fa [2], ls [2], fs [2];
    logic [20:0] ex [2];

    frame_line_timer #(
        .NRM_LEN(10), .NRM_ACT(6), .EXT_ACT(8), .V_ACT(3),
        .NRM_LINES('{32'd5, 32'd6, 32'd7, 32'd8, 32'd9, 32'd10, 32'd11, 32'd12}),
        .EXT_LEN('{32'd30, 32'd12, 32'd14, 32'd16, 32'd18, 32'd20, 32'd22, 32'd24})
    ) u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .rate_code(rate_code), .ext_mode(ext_mode),
        .clk_cnt(cc[0]), .line_cnt(lc[0]), .line_active(la[0]), .frame_active(fa[0]),
        .line_start(ls[0]), .frame_start(fs[0]), .max_expo(ex[0])
    );

    frame_line_timer u1 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .rate_code(rate_code), .ext_mode(ext_mode),
        .clk_cnt(cc[1]), .line_cnt(lc[1]), .line_active(la[1]), .frame_active(fa[1]),
        .line_start(ls[1]), .frame_start(fs[1]), .max_expo(ex[1])
    );

    // Reference tables, from the requirements
    int nrm_len [2] = '{10, 1716};
    int nrm_act [2] = '{6, 1408};
    int ext_act [2] = '{8, 2816};
    int vact    [2] = '{3, 289};
    int nrm_lines [2][8] = '{'{5, 6, 7, 8, 9, 10, 11, 12},
                             '{467, 583, 700, 933, 1166, 1749, 3497, 13987}};
    int ext_len   [2][8] = '{'{12, 12, 14, 16, 18, 20, 22, 24},
                             '{3464, 3464, 4152, 5536, 6920, 10384, 20760, 83048}};
    int expo_n [8] = '{99957, 124839, 149935, 199914, 249892, 374946, 749892, 2097151};
    int expo_e [8] = '{124704, 124704, 149472, 199296, 249120, 373824, 747360, 2097151};

    int mh [2], mv [2], mcode [2];
    bit mext [2];
    bit started = 1'b0;
    int n_run = 0;
    int n_fail = 0;

    function automatic int len_of(int i);
        return mext[i] ? ext_len[i][mcode[i]] : nrm_len[i];
    endfunction
    function automatic int lines_of(int i);
        return mext[i] ? vact[i] : nrm_lines[i][mcode[i]];
    endfunction

    // Behavioural model, advanced on each rising edge with the pre-edge inputs
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                mh[i] = 0; mv[i] = 0; mcode[i] = int'(rate_code); mext[i] = ext_mode;
            end else if (clk_en) begin
                if (mh[i] == len_of(i) - 1) begin
                    mh[i] = 0;
                    if (mv[i] == lines_of(i) - 1) begin
                        mv[i] = 0; mcode[i] = int'(rate_code); mext[i] = ext_mode;
                    end else mv[i] = mv[i] + 1;
                end else mh[i] = mh[i] + 1;
            end
        end
        started = 1'b1;
    end

    task automatic chk(string tag, int i, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s u%0d t=%0t actual=%0d expected=%0d", tag, i, $time, act, exp);
        end
    endtask

    // Compare every output of both instances away from the active edge
    always @(negedge clk) begin
        if (started) begin
            for (int i = 0; i < 2; i++) begin
                int ecode;
                bit els;
                ecode = (mext[i] && mcode[i] == 0) ? 1 : mcode[i];
                els = clk_en && (mh[i] == 0);
                chk("R2 R5 R6 R8 clk_cnt", i, int'(cc[i]), mh[i]);
                chk("R3 R9 line_cnt", i, int'(lc[i]), mv[i]);
                chk("R2 R5 line_active", i, int'(la[i]),
                    int'(mh[i] < (mext[i] ? ext_act[i] : nrm_act[i])));
                chk("R4 frame_active", i, int'(fa[i]), int'(mv[i] < vact[i]));
                chk("R7 R8 line_start", i, int'(ls[i]), int'(els));
                chk("R7 R8 frame_start", i, int'(fs[i]), int'(els && mv[i] == 0));
                chk("R10 R6 max_expo", i, int'(ex[i]),
                    mext[i] ? expo_e[ecode] : expo_n[ecode]);
            end
        end
    end

    task automatic do_reset(logic [2:0] code, logic ext);
        @(posedge clk); #2;
        rst = 1'b1; clk_en = 1'b0; rate_code = code; ext_mode = ext;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        // R1: counters cleared, strobes idle with enable low
        for (int i = 0; i < 2; i++) begin
            chk("R1 reset clk_cnt", i, int'(cc[i]), 0);
            chk("R1 reset line_cnt", i, int'(lc[i]), 0);
            chk("R1 reset line_start", i, int'(ls[i]), 0);
        end
        @(posedge clk); #2;
        rst = 1'b0;
    endtask

    // gap: 0 = enable always high, else enable low with probability 1/gap
    task automatic run(int n, int gap, bit churn);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            clk_en = (gap == 0) ? 1'b1 : (($urandom % gap) != 0);
            if (churn) begin
                rate_code = 3'($urandom);
                ext_mode  = 1'($urandom);
            end
        end
    endtask

    initial begin
        // R2 R3 R9: normal mode code 0, then a mid-frame code change
        do_reset(3'd0, 1'b0);
        run(1900, 0, 1'b0);
        rate_code = 3'd3;
        run(1900, 0, 1'b0);
        // R5 R6: extended mode, code 0 borrows code 1 timing
        do_reset(3'd0, 1'b1);
        run(7500, 0, 1'b0);
        rate_code = 3'd5;
        run(500, 0, 1'b0);
        // R8: enable gaps in extended mode code 6
        do_reset(3'd6, 1'b1);
        run(5000, 3, 1'b0);
        // R10: slowest normal code
        do_reset(3'd7, 1'b0);
        run(2000, 4, 1'b0);
        // R9: settings churn every cycle, gaps hit the wrap cycle too
        do_reset(3'd2, 1'b0);
        run(6000, 3, 1'b1);
        run(3000, 0, 1'b1);
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule